// File: doc/BRIEF.md
# Nibble-Serial Boot-Flash Bus Target

This block is the target side of a nibble-serial host bus for boot storage. Every transfer shares one 4-bit data path with a frame strobe that is active low. The host opens a cycle with a start nibble and a device-select nibble. It then shifts in a seven-nibble address and a size nibble and, for a write, one data byte. After a two-clock turnaround the target takes over the bus. It reports progress with sync nibbles and returns read data, then hands the bus back through a closing turnaround.

Toward the storage core the block presents a byte request: address, direction, write byte, and a request strobe held until the core answers with ready. A core error flag may accompany ready. While the core has not answered, the target keeps the cycle alive with long-wait syncs. A new frame strobe in the middle of a cycle abandons that cycle at once. The bus is released and decoding restarts from the nibble that came with the strobe.

The 4-bit bus is split into an input, an output and an output enable so that the pad tri-state sits outside the block.

Top module: `nibble_bus_target`

## Requirements
- R1: After reset the target does not drive the bus (`bus_oe` = 0) and raises no core request.
- R2: With `frame_n` low, start nibble 4'b1101 opens a read and 4'b1110 opens a write (`core_we` = 1). Any other start value is ignored: the bus stays undriven and no request is raised.
- R3: The nibble after the start is compared with `strap_id`. On a mismatch the target neither drives the bus nor requests the core until the next frame strobe.
- R4: The address arrives on seven consecutive clocks with the most significant nibble first. The low ADDR_W bits (18 by default) of the 28 collected bits appear on `core_addr`.
- R5: The size nibble follows the address. Only 4'b0000 (one byte) is served. Any other size leaves the target silent for the rest of the cycle.
- R6: In a write, the two nibbles after the size form the data byte, with bits 3:0 first and bits 7:4 second. The byte is presented on `core_wdata`.
- R7: In the host-to-target turnaround the target stays off the bus for both clocks. It closes every completed cycle by driving 4'b1111 for one clock and then releasing the bus.
- R8: The target drives the long-wait sync 4'b0110 for every clock in which the core has not yet signalled ready. If ready comes on the last turnaround clock, no wait nibble is sent.
- R9: The final sync is 4'b0000 when ready comes without error and 4'b1010 when `core_err` accompanies ready. No other sync value is ever produced.
- R10: In a read, the byte latched from `core_rdata` follows the sync, with bits 3:0 in the first clock and bits 7:4 in the second.
- R11: A low `frame_n` during any cycle phase releases the bus on the next clock. It also withdraws any core request.
- R12: `core_req` rises on the last turnaround clock and stays high until the clock in which `core_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe marking a start nibble |
| bus_in | input | 4 | Nibble received from the shared bus |
| bus_out | output | 4 | Nibble the target places on the bus |
| bus_oe | output | 1 | Output enable for the bus pads |
| strap_id | input | 4 | Device-select value this target answers to |
| core_req | output | 1 | Byte access request toward the core |
| core_we | output | 1 | 1 for a write access, 0 for a read |
| core_addr | output | ADDR_W | Byte address toward the core |
| core_wdata | output | 8 | Write byte toward the core |
| core_rdata | input | 8 | Read byte from the core, taken with ready |
| core_ready | input | 1 | Core has completed the access |
| core_err | input | 1 | Core reports a failed access, valid with ready |

## Verification
The hardest situation to reach from the ports is an abort that lands while the target owns the bus and the core request is pending. The host must first complete a full read preamble and hold the core model in its not-ready state, so the block sits in long-wait. Only then does it pulse the frame strobe. The bench drives that exact path. It then runs a full cycle to show that nothing survived. It also sweeps all sixteen start codes, all select values, all nonzero sizes, and the combinations of direction, wait count and error.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_ADDR,
      ST_SIZE,
      ST_WLO,
      ST_WHI,
      ST_HTA0,
      ST_HTA1,
      ST_WAIT,
      ST_SYNC,
      ST_RLO,
      ST_RHI,
      ST_TTA0,
      ST_TTA1,
      ST_MUTE
   } nbt_state_e;

   localparam logic [3:0] NBT_OPEN_RD   = 4'b1101;
   localparam logic [3:0] NBT_OPEN_WR   = 4'b1110;
   localparam logic [3:0] NBT_SIZE_BYTE = 4'b0000;
   localparam logic [3:0] NBT_SYNC_OK   = 4'b0000;
   localparam logic [3:0] NBT_SYNC_LONG = 4'b0110;
   localparam logic [3:0] NBT_SYNC_ERR  = 4'b1010;
   localparam logic [3:0] NBT_TAR_HIGH  = 4'b1111;

endpackage

// File: rtl/nbt_addr_shift.sv
module nbt_addr_shift #(
   parameter int ADDR_W  = 18,
   parameter int NIBBLES = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift,
   input  logic [3:0]        nib,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   localparam int CNT_W = $clog2(NIBBLES + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (shift) begin
         addr_q <= {addr_q[ADDR_W-5:0], nib};
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign addr = addr_q;
   assign last = (cnt_q == CNT_W'(NIBBLES - 1));

   // R4
   addr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> (cnt_q < CNT_W'(NIBBLES)));

endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
   import nbt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] nib_in,
   input  logic [3:0] strap_id,
   input  logic       core_ready,
   input  logic       addr_last,
   output nbt_state_e state,
   output logic       is_write,
   output logic       core_req
);
   nbt_state_e st_q, st_d;
   logic       wr_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: st_d = ST_IDLE;
         ST_SEL:  st_d = (nib_in == strap_id) ? ST_ADDR : ST_MUTE;
         ST_ADDR: st_d = addr_last ? ST_SIZE : ST_ADDR;
         ST_SIZE: begin
            if (nib_in != NBT_SIZE_BYTE) st_d = ST_MUTE;
            else                         st_d = wr_q ? ST_WLO : ST_HTA0;
         end
         ST_WLO:  st_d = ST_WHI;
         ST_WHI:  st_d = ST_HTA0;
         ST_HTA0: st_d = ST_HTA1;
         ST_HTA1: st_d = core_ready ? ST_SYNC : ST_WAIT;
         ST_WAIT: st_d = core_ready ? ST_SYNC : ST_WAIT;
         ST_SYNC: st_d = wr_q ? ST_TTA0 : ST_RLO;
         ST_RLO:  st_d = ST_RHI;
         ST_RHI:  st_d = ST_TTA0;
         ST_TTA0: st_d = ST_TTA1;
         ST_TTA1: st_d = ST_IDLE;
         ST_MUTE: st_d = ST_MUTE;
         default: st_d = ST_IDLE;
      endcase
      if (!frame_n) begin
         st_d = ((nib_in == NBT_OPEN_RD) || (nib_in == NBT_OPEN_WR)) ? ST_SEL : ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         wr_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (!frame_n) wr_q <= (nib_in == NBT_OPEN_WR);
      end
   end

   assign state    = st_q;
   assign is_write = wr_q;
   assign core_req = (st_q == ST_HTA1) || (st_q == ST_WAIT);

endmodule

// File: rtl/nbt_data.sv
module nbt_data
   import nbt_pkg::*;
#(
   parameter bit ERR_SYNC_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  nbt_state_e state,
   input  logic [3:0] nib_in,
   input  logic       capture,
   input  logic [7:0] core_rdata,
   input  logic       core_err,
   output logic [7:0] wbyte,
   output logic [7:0] rbyte,
   output logic       err
);
   logic [7:0] wbyte_q, rbyte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbyte_q <= '0;
         rbyte_q <= '0;
      end else begin
         if (frame_n && state == ST_WLO) wbyte_q[3:0] <= nib_in;
         if (frame_n && state == ST_WHI) wbyte_q[7:4] <= nib_in;
         if (capture) rbyte_q <= core_rdata;
      end
   end

   generate
      if (ERR_SYNC_EN) begin : g_err
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       err_q <= 1'b0;
            else if (capture) err_q <= core_err;
         end
         assign err = err_q;
      end else begin : g_noerr
         assign err = 1'b0;
      end
   endgenerate

   assign wbyte = wbyte_q;
   assign rbyte = rbyte_q;

endmodule

// File: rtl/nbt_drive.sv
module nbt_drive
   import nbt_pkg::*;
(
   input  nbt_state_e state,
   input  logic [7:0] rbyte,
   input  logic       err,
   output logic [3:0] nib_out,
   output logic       nib_oe
);
   always_comb begin
      nib_out = 4'b0000;
      nib_oe  = 1'b1;
      unique case (state)
         ST_WAIT: nib_out = NBT_SYNC_LONG;
         ST_SYNC: nib_out = err ? NBT_SYNC_ERR : NBT_SYNC_OK;
         ST_RLO:  nib_out = rbyte[3:0];
         ST_RHI:  nib_out = rbyte[7:4];
         ST_TTA0: nib_out = NBT_TAR_HIGH;
         default: nib_oe  = 1'b0;
      endcase
   end

endmodule

// File: rtl/nibble_bus_target.sv
module nibble_bus_target
   import nbt_pkg::*;
#(
   parameter int ADDR_W       = 18,
   parameter int ADDR_NIBBLES = 7,
   parameter bit ERR_SYNC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        bus_in,
   output logic [3:0]        bus_out,
   output logic              bus_oe,
   input  logic [3:0]        strap_id,
   output logic              core_req,
   output logic              core_we,
   output logic [ADDR_W-1:0] core_addr,
   output logic [7:0]        core_wdata,
   input  logic [7:0]        core_rdata,
   input  logic              core_ready,
   input  logic              core_err
);
   localparam int ADDR_BITS_SENT = 4 * ADDR_NIBBLES;

   initial begin
      if (ADDR_W < 5 || ADDR_W > ADDR_BITS_SENT)
         $fatal(1, "nibble_bus_target: ADDR_W out of range");
   end

   nbt_state_e st;
   logic       addr_last;
   logic       wr;
   logic [7:0] rbyte;
   logic       err;

   nbt_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .nib_in     (bus_in),
      .strap_id   (strap_id),
      .core_ready (core_ready),
      .addr_last  (addr_last),
      .state      (st),
      .is_write   (wr),
      .core_req   (core_req)
   );

   nbt_addr_shift #(.ADDR_W(ADDR_W), .NIBBLES(ADDR_NIBBLES)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st == ST_SEL),
      .shift (frame_n && st == ST_ADDR),
      .nib   (bus_in),
      .addr  (core_addr),
      .last  (addr_last)
   );

   nbt_data #(.ERR_SYNC_EN(ERR_SYNC_EN)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .state      (st),
      .nib_in     (bus_in),
      .capture    (core_req && core_ready),
      .core_rdata (core_rdata),
      .core_err   (core_err),
      .wbyte      (core_wdata),
      .rbyte      (rbyte),
      .err        (err)
   );

   nbt_drive u_drive (
      .state   (st),
      .rbyte   (rbyte),
      .err     (err),
      .nib_out (bus_out),
      .nib_oe  (bus_oe)
   );

   assign core_we = wr;

   // R11
   frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> (!bus_oe && !core_req));

   // R7
   tar_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_oe) && $past(frame_n)) |-> ($past(bus_out) == NBT_TAR_HIGH));

   // R8
   long_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && core_req) |-> (bus_out == NBT_SYNC_LONG));

   // R9
   sync_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && st == ST_SYNC) |-> (bus_out == NBT_SYNC_OK || bus_out == NBT_SYNC_ERR));

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && !core_ready && frame_n) |=> core_req);

endmodule

// File: tb/sim_nibble_bus_target.sv
`timescale 1ns/1ps
module sim_nibble_bus_target;
   localparam logic [3:0] STRAP = 4'h3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  bus_in = 4'h0;
   logic [3:0]  bus_out;
   logic        bus_oe;
   logic        core_req, core_we, core_ready = 1'b0;
   logic [17:0] core_addr;
   logic [7:0]  core_wdata, core_rdata;
   logic        err_mode = 1'b0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   assign core_rdata = core_addr[7:0] ^ 8'hA5;

   nibble_bus_target u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .strap_id(STRAP),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_rdata(core_rdata),
      .core_ready(core_ready), .core_err(err_mode)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic fr, input logic [3:0] nb, input logic rdy);
      frame_n = fr; bus_in = nb; core_ready = rdy;
      @(posedge clk); #1;
   endtask

   task automatic silent(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         step(1'b1, 4'(i * 7 + 3), 1'b0);
         chk(!bus_oe && !core_req, req, {bus_oe, core_req}, 0);
      end
   endtask

   task automatic run_cycle(input bit wr, input logic [27:0] a, input logic [7:0] wd,
                            input int w, input bit e);
      logic [7:0] rexp;
      rexp = a[7:0] ^ 8'hA5;
      err_mode = e;
      step(1'b0, wr ? 4'b1110 : 4'b1101, 1'b0);
      chk(!bus_oe, "R2 start", bus_oe, 0);
      step(1'b1, STRAP, 1'b0);
      chk(!bus_oe, "R3 select", bus_oe, 0);
      for (int i = 0; i < 7; i++) begin
         step(1'b1, a[27 - 4*i -: 4], 1'b0);
         chk(!bus_oe, "R4 addr phase", bus_oe, 0);
      end
      step(1'b1, 4'b0000, 1'b0);
      chk(!bus_oe, "R5 size", bus_oe, 0);
      if (wr) begin
         step(1'b1, wd[3:0], 1'b0);
         step(1'b1, wd[7:4], 1'b0);
         chk(!bus_oe, "R6 wdata phase", bus_oe, 0);
      end
      step(1'b1, 4'hF, 1'b0);
      chk(!bus_oe, "R7 host turnaround", bus_oe, 0);
      for (int k = 0; k <= w; k++) begin
         chk(core_req, "R12 req held", core_req, 1);
         if (k == w) begin
            chk(core_addr == a[17:0], "R4 addr", core_addr, a[17:0]);
            chk(core_we == wr, "R2 direction", core_we, wr);
            if (wr) chk(core_wdata == wd, "R6 wdata", core_wdata, wd);
         end
         step(1'b1, 4'h0, k == w);
         if (k < w) chk(bus_oe && bus_out == 4'b0110, "R8 long wait", {bus_oe, bus_out}, 5'h16);
         else       chk(bus_oe && bus_out == (e ? 4'b1010 : 4'b0000), "R9 sync",
                        {bus_oe, bus_out}, e ? 5'h1A : 5'h10);
      end
      chk(!core_req, "R12 req dropped", core_req, 0);
      if (!wr) begin
         step(1'b1, 4'h0, 1'b0);
         chk(bus_oe && bus_out == rexp[3:0], "R10 rdata low", bus_out, rexp[3:0]);
         step(1'b1, 4'h0, 1'b0);
         chk(bus_oe && bus_out == rexp[7:4], "R10 rdata high", bus_out, rexp[7:4]);
      end
      step(1'b1, 4'h0, 1'b0);
      chk(bus_oe && bus_out == 4'hF, "R7 close high", {bus_oe, bus_out}, 5'h1F);
      step(1'b1, 4'h0, 1'b0);
      chk(!bus_oe, "R7 release", bus_oe, 0);
      step(1'b1, 4'h0, 1'b0);
      chk(!bus_oe && !core_req, "R1 back to idle", {bus_oe, core_req}, 0);
   endtask

   initial begin
      #500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!bus_oe && !core_req, "R1 reset", {bus_oe, core_req}, 0);
      rst_n = 1'b1;
      step(1'b1, 4'h0, 1'b0);
      chk(!bus_oe && !core_req, "R1 after reset", {bus_oe, core_req}, 0);

      // R2 sweep of every start code
      for (int s = 0; s < 16; s++) begin
         if (s == 13 || s == 14) begin
            run_cycle(s == 14, 28'h00A5C3 + 28'(s), 8'(s * 17), 1, 1'b0);
         end else begin
            step(1'b0, 4'(s), 1'b0);
            silent("R2 ignored start", 12);
         end
      end

      // R3 sweep of every select value
      for (int id = 0; id < 16; id++) begin
         if (id == int'(STRAP)) continue;
         step(1'b0, 4'b1101, 1'b0);
         step(1'b1, 4'(id), 1'b0);
         silent("R3 select mismatch", 16);
      end

      // R5 sweep of every nonzero size
      for (int sz = 1; sz < 16; sz++) begin
         step(1'b0, 4'b1110, 1'b0);
         step(1'b1, STRAP, 1'b0);
         for (int i = 0; i < 7; i++) step(1'b1, 4'(i + sz), 1'b0);
         step(1'b1, 4'(sz), 1'b0);
         silent("R5 unsupported size", 6);
      end

      // R6 R8 R9 R10 sweep of direction, wait count and error
      for (int wr = 0; wr < 2; wr++)
         for (int w = 0; w < 4; w++)
            for (int e = 0; e < 2; e++)
               run_cycle(wr[0], 28'(32'h0F13579 * (w + 1) + 32'h3A7 * e + wr),
                         8'(w * 61 + e * 29 + wr * 7 + 5), w, e[0]);

      // R11 abort while long-wait is driven
      step(1'b0, 4'b1101, 1'b0);
      step(1'b1, STRAP, 1'b0);
      for (int i = 0; i < 7; i++) step(1'b1, 4'(i), 1'b0);
      step(1'b1, 4'h0, 1'b0);
      step(1'b1, 4'hF, 1'b0);
      step(1'b1, 4'h0, 1'b0);
      chk(bus_oe && core_req, "R11 precondition wait", {bus_oe, core_req}, 3);
      step(1'b0, 4'h0, 1'b0);
      chk(!bus_oe && !core_req, "R11 abort releases", {bus_oe, core_req}, 0);
      silent("R11 stays idle", 4);
      run_cycle(1'b0, 28'hFFFFFFF, 8'h00, 0, 1'b0);

      // R11 abort during read data, restart with a write
      step(1'b0, 4'b1101, 1'b0);
      step(1'b1, STRAP, 1'b0);
      for (int i = 0; i < 7; i++) step(1'b1, 4'(15 - i), 1'b0);
      step(1'b1, 4'h0, 1'b0);
      step(1'b1, 4'hF, 1'b0);
      step(1'b1, 4'h0, 1'b1);
      step(1'b1, 4'h0, 1'b0);
      chk(bus_oe, "R11 precondition rdata", bus_oe, 1);
      step(1'b0, 4'b1110, 1'b0);
      chk(!bus_oe, "R11 abort in data", bus_oe, 0);
      step(1'b1, 4'hE, 1'b0);
      silent("R11 restarted select mismatch", 4);
      run_cycle(1'b1, 28'h0000000, 8'hFF, 2, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule